// File: doc/BRIEF.md
# Glitch-free clock source switch

This block picks the system clock from several free-running sources that bear no phase relation to one another. Software writes a small select field. The block then moves the system clock from the source that drives it now to the one just named. No shortened high or low phase ever appears on the output.

Each candidate source has a ready flag from its own start-up timer. The block keeps the current source on the output until the new source is ready. It then runs a two-sided handshake. The old source counts its own rising edges and turns off on one of its falling edges. Next, the new source counts its own rising edges and turns on on one of its falling edges. Between these two steps the output stays low, so every switch pauses the system clock briefly, whether the new source is faster or slower.

A busy flag tells software that a switch is pending. A select written while a switch is in progress is taken up once the current switch has finished.

Top module: `clk_source_switch`

## Requirements
- R1: While reset is asserted and right after it is released, the source numbered DEF_SRC (0 by default) drives sys_clk with no handshake, and switch_busy is 0.
- R2: Writing the select value of the source that already drives sys_clk leaves switch_busy at 0 and causes no pause: sys_clk keeps one rising edge for every rising edge of that source.
- R3: While the ready bit of the selected source (src_ready bit n for select value n) is 0, sys_clk keeps following the old source with no pause, and switch_busy stays 1.
- R4: Once the new source is selected and ready, the old source keeps driving sys_clk for two more of its own rising edges. From its next falling edge sys_clk is held low.
- R5: While sys_clk is held low, it shows no rising edge. The hold ends on the first falling edge of the new source that follows two of its rising edges counted from the start of the hold. The next rising edge of the new source then appears on sys_clk.
- R6: Every sys_clk rising edge coincides with a rising edge of the source the switch has reached. Every high phase of sys_clk lasts exactly half the period of that source, so no runt pulses occur.
- R7: switch_busy rises as soon as src_sel differs from the active source. It stays 1 through the hold and falls at the falling edge of the new source that ends the hold.
- R8: A select written during a switch is kept. Once the current switch is complete, the block starts a full new switch to it on the first rising edge of the new source, and never jumps straight to it.
- R9: At most one source is ever gated onto sys_clk. A source is gated on only after all other sources have been gated off.
- R10: Switches work in both directions between a fast and a slow source, and to and from every one of the 2**SEL_W sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 2**SEL_W | Candidate clock sources, bit n is source n |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_ready | input | 2**SEL_W | Start-up-timer ready flag of each source |
| src_sel | input | SEL_W | Requested source number |
| sys_clk | output | 1 | Selected system clock |
| switch_busy | output | 1 | High while a requested switch has not completed |

## Verification
The assertions watch, on every edge of every source, that at most one gate enable is active. They also check that an enable rises only after all the others were off, that an old source holds while its successor is not ready, and that an idle busy flag means the selected source is gated on. Only the bench scenarios can show the exact edge counts of the handshake. That covers the two old rising edges before the hold, the two new rising edges before the release, pulse widths on the output, the pause-free re-selection of the active source, and the order in which a select queued during a hold is served.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
   // Fewest flops a crossing chain may have.
   localparam int SYNC_MIN = 2;
   // Widest source vector the helper below handles.
   localparam int VEC_MAX  = 32;

   // True when any bit other than idx is set in vec.
   function automatic logic any_other(input logic [VEC_MAX-1:0] vec, input int idx);
      logic [VEC_MAX-1:0] mask;
      mask = ~(VEC_MAX'(1) << idx);
      return |(vec & mask);
   endfunction
endpackage

// File: rtl/csw_sync.sv
`timescale 1ns/1ps
module csw_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < csw_pkg::SYNC_MIN) begin : g_bad_depth
         $error("csw_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csw_gate_cell.sv
`timescale 1ns/1ps
module csw_gate_cell #(
   parameter int STAGES     = 2,
   parameter bit IS_DEFAULT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   output logic en,
   output logic gated
);
   logic on_s, off_s;

   csw_sync #(.STAGES(STAGES), .RST_VAL(IS_DEFAULT)) u_on_sync (
      .clk(clk), .rst_n(rst_n), .d(on_req), .q(on_s));

   csw_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_off_sync (
      .clk(clk), .rst_n(rst_n), .d(off_req), .q(off_s));

   // Enable moves only while this clock is low, so the AND below never chops a phase.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)     en <= IS_DEFAULT;
      else if (off_s) en <= 1'b0;
      else if (on_s)  en <= 1'b1;
   end

   assign gated = clk & en;
endmodule

// File: rtl/csw_sel_track.sv
`timescale 1ns/1ps
module csw_sel_track #(
   parameter int SEL_W   = 2,
   parameter int DEF_SRC = 0,
   localparam int NUM    = 1 << SEL_W
) (
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [NUM-1:0]   en_vec,
   output logic [SEL_W-1:0] sel_hold,
   output logic             busy
);
   logic settled;

   assign settled = en_vec[sel_hold];

   // The target only moves while the current target is switched in.
   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n)       sel_hold <= SEL_W'(DEF_SRC);
      else if (settled) sel_hold <= sel_in;
   end

   assign busy = (sel_in != sel_hold) | ~settled;
endmodule

// File: rtl/clk_source_switch.sv
`timescale 1ns/1ps
module clk_source_switch #(
   parameter int SEL_W       = 2,
   parameter int DEF_SRC     = 0,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_SRC    = 1 << SEL_W
) (
   input  logic [NUM_SRC-1:0] clk_src,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_ready,
   input  logic [SEL_W-1:0]   src_sel,
   output logic               sys_clk,
   output logic               switch_busy
);
   generate
      if (SEL_W < 1 || NUM_SRC > csw_pkg::VEC_MAX) begin : g_bad_width
         $error("clk_source_switch: SEL_W out of range");
      end
      if (DEF_SRC < 0 || DEF_SRC >= NUM_SRC) begin : g_bad_default
         $error("clk_source_switch: DEF_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_vec;
   logic [NUM_SRC-1:0] gated_vec;
   logic [NUM_SRC-1:0] on_req;
   logic [NUM_SRC-1:0] off_req;
   logic [SEL_W-1:0]   sel_hold;
   logic               tgt_ready;

   assign tgt_ready = src_ready[sel_hold];

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign on_req[i]  = (sel_hold == SEL_W'(i)) & src_ready[i]
                           & ~csw_pkg::any_other(csw_pkg::VEC_MAX'(en_vec), i);
         assign off_req[i] = (sel_hold != SEL_W'(i)) & tgt_ready;

         csw_gate_cell #(.STAGES(SYNC_STAGES), .IS_DEFAULT(i == DEF_SRC)) u_cell (
            .clk    (clk_src[i]),
            .rst_n  (rst_n),
            .on_req (on_req[i]),
            .off_req(off_req[i]),
            .en     (en_vec[i]),
            .gated  (gated_vec[i]));
      end
   endgenerate

   assign sys_clk = |gated_vec;

   csw_sel_track #(.SEL_W(SEL_W), .DEF_SRC(DEF_SRC)) u_sel (
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .sel_in  (src_sel),
      .en_vec  (en_vec),
      .sel_hold(sel_hold),
      .busy    (switch_busy));
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker #(
   parameter int SEL_W = 2,
   localparam int NUM  = 1 << SEL_W
) (
   input logic [NUM-1:0]   clk_src,
   input logic             rst_n,
   input logic [NUM-1:0]   src_ready,
   input logic [SEL_W-1:0] src_sel,
   input logic             sys_clk,
   input logic             switch_busy,
   input logic [NUM-1:0]   en_vec,
   input logic [SEL_W-1:0] sel_hold
);
   generate
      for (genvar k = 0; k < NUM; k++) begin : g_chk
         // R9: never two sources gated at once
         a_r9_single_enable: assert property (@(posedge clk_src[k]) disable iff (!rst_n)
            $onehot0(en_vec));

         // R9: a source turns on only after every other was already off
         a_r9_on_after_others_off: assert property (@(posedge clk_src[k]) disable iff (!rst_n)
            $rose(en_vec[k]) |-> (($past(en_vec) & ~(NUM'(1) << k)) == '0));

         // R3: the old source stays gated while its successor is not ready
         a_r3_old_holds: assert property (@(posedge clk_src[k]) disable iff (!rst_n)
            (en_vec[k] && sel_hold != SEL_W'(k) && !src_ready[sel_hold]) |=> en_vec[k]);
      end
   endgenerate

   // R7: an idle busy flag means the requested source is gated onto the output
   a_r7_idle_means_running: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !switch_busy |-> en_vec[src_sel]);
endmodule

bind clk_source_switch csw_checker #(.SEL_W(SEL_W)) u_csw_chk (
   .clk_src    (clk_src),
   .rst_n      (rst_n),
   .src_ready  (src_ready),
   .src_sel    (src_sel),
   .sys_clk    (sys_clk),
   .switch_busy(switch_busy),
   .en_vec     (en_vec),
   .sel_hold   (sel_hold));

// File: tb/clk_source_switch_test.sv
`timescale 1ns/1ps
module clk_source_switch_test;
   localparam real CLK_PERIOD = 10.0;
   localparam real HALF0 = CLK_PERIOD / 2.0;
   localparam real HALF1 = 7.3;
   localparam real HALF2 = 11.9;
   localparam real HALF3 = 3.1;

   logic c0, c1, c2, c3;
   logic [3:0] clk_src;
   logic       rst_n;
   logic [3:0] src_ready;
   logic [1:0] src_sel;
   logic       sys_clk, switch_busy;

   assign clk_src = {c3, c2, c1, c0};

   clk_source_switch uut (
      .clk_src(clk_src), .rst_n(rst_n), .src_ready(src_ready),
      .src_sel(src_sel), .sys_clk(sys_clk), .switch_busy(switch_busy));

   initial begin c0 = 0; #0.7; forever #(HALF0) c0 = ~c0; end
   initial begin c1 = 0; #1.9; forever #(HALF1) c1 = ~c1; end
   initial begin c2 = 0; #2.3; forever #(HALF2) c2 = ~c2; end
   initial begin c3 = 0; #0.4; forever #(HALF3) c3 = ~c3; end

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   real half_of[4];
   real last_rise[4];
   real t_hi = 0.0;
   int  exp_src = 0;
   bit  hold_expected = 0;
   bit  mon_on = 0;
   int  sys_rises = 0;
   int  pend_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   always @(posedge c0) last_rise[0] = $realtime;
   always @(posedge c1) last_rise[1] = $realtime;
   always @(posedge c2) last_rise[2] = $realtime;
   always @(posedge c3) last_rise[3] = $realtime;

   // Reference model compared on every output edge.
   always @(posedge sys_clk) begin
      if (mon_on) begin
         real t;
         t = $realtime;
         t_hi = t;
         sys_rises++;
         #0.05;
         if (hold_expected)
            chk(0, "R5", "rising edge during hold", 1, 0);
         else
            chk(last_rise[exp_src] == t, "R6", "edge aligned to expected source",
                longint'(t * 1000.0), longint'(last_rise[exp_src] * 1000.0));
      end
   end

   always @(negedge sys_clk) begin
      if (mon_on && t_hi > 0.0) begin
         real w;
         w = $realtime - t_hi;
         chk((w - half_of[exp_src] < 0.01) && (half_of[exp_src] - w < 0.01), "R6",
             "high phase width ps", longint'(w * 1000.0), longint'(half_of[exp_src] * 1000.0));
      end
   end

   task automatic wait_rise(input int s);
      case (s)
         0: @(posedge c0);
         1: @(posedge c1);
         2: @(posedge c2);
         default: @(posedge c3);
      endcase
   endtask

   task automatic wait_fall(input int s);
      case (s)
         0: @(negedge c0);
         1: @(negedge c1);
         2: @(negedge c2);
         default: @(negedge c3);
      endcase
   endtask

   // pre_rises: old rising edges still due before the hold (3 when the select is written here).
   task automatic do_switch(input int to, input int pre_rises, input bit late_ready);
      int from = exp_src;
      int eff  = pre_rises;
      if (pre_rises == 3) begin
         wait_fall(from);
         #0.1 src_sel = 2'(to);
         #0.05 chk(switch_busy === 1'b1, "R7", "busy right after select", switch_busy, 1);
      end
      if (late_ready) begin
         int s0 = sys_rises;
         repeat (12) wait_rise(from);
         #0.05;
         chk(switch_busy === 1'b1, "R3", "busy while target not ready", switch_busy, 1);
         chk(sys_rises - s0 == 12, "R3", "old source keeps running", sys_rises - s0, 12);
         wait_fall(from);
         #0.1 src_ready[to] = 1'b1;
         eff = 2;
      end
      repeat (eff) wait_rise(from);
      #0.05 chk(sys_clk === 1'b1, "R4", "old still drives last edge", sys_clk, 1);
      wait_fall(from);
      hold_expected = 1;
      if (pend_q.size() > 0) #0.1 src_sel = 2'(pend_q[0]);
      wait_rise(to);
      wait_rise(to);
      #0.05;
      chk(switch_busy === 1'b1, "R7", "busy during hold", switch_busy, 1);
      chk(sys_clk === 1'b0, "R5", "output low during hold", sys_clk, 0);
      wait_fall(to);
      hold_expected = 0;
      exp_src = to;
      #0.05 chk(switch_busy === (pend_q.size() > 0), "R7", "busy after release",
                switch_busy, pend_q.size() > 0);
      wait_rise(to);
      #0.05 chk(sys_clk === 1'b1, "R5", "new source switched in", sys_clk, 1);
   endtask

   initial begin
      half_of[0] = HALF0; half_of[1] = HALF1; half_of[2] = HALF2; half_of[3] = HALF3;
      for (int k = 0; k < 4; k++) last_rise[k] = -1.0;
      rst_n = 0; src_sel = 2'd0; src_ready = 4'b1011;
      #12.2;
      // R1: default source drives the output during reset
      chk(switch_busy === 1'b0, "R1", "busy in reset", switch_busy, 0);
      chk(sys_clk === c0, "R1", "output follows source 0 in reset", sys_clk, c0);
      #11.1 rst_n = 1;
      wait_fall(0);
      mon_on = 1;
      wait_rise(0);
      #0.05;
      chk(sys_clk === 1'b1, "R1", "output follows source 0 after reset", sys_clk, 1);
      chk(switch_busy === 1'b0, "R1", "busy after reset", switch_busy, 0);

      // R2: re-select the active source
      begin
         int s0;
         wait_fall(0);
         #0.1 src_sel = 2'd0;
         s0 = sys_rises;
         #0.05 chk(switch_busy === 1'b0, "R2", "no busy on same source", switch_busy, 0);
         repeat (10) wait_rise(0);
         #0.05;
         chk(sys_rises - s0 == 10, "R2", "no pause on same source", sys_rises - s0, 10);
         chk(switch_busy === 1'b0, "R2", "still idle", switch_busy, 0);
      end

      do_switch(1, 3, 0);   // R10 fast to slow
      do_switch(3, 3, 0);   // R10 slow to fast
      do_switch(2, 3, 1);   // R3 target becomes ready late
      pend_q.push_back(0);
      do_switch(1, 3, 0);   // R8 select 0 written during the hold
      void'(pend_q.pop_front());
      do_switch(0, 2, 0);   // R8 queued switch served afterwards
      repeat (4) wait_rise(0);
      #0.05 chk(switch_busy === 1'b0, "R8", "idle after queued switch", switch_busy, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule